// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. When software loads a selector, the block fetches the matching 8-byte descriptor from a table in memory. The entry's address is the table base plus eight times the selector. The fetch uses two 32-bit reads over a simple request/valid read port. The block decodes the entry into a hidden segment register, so later accesses need no memory traffic.

Each access request returns, one cycle after it is accepted, the segment base plus the offset and a fault code. The fault code reports an offset beyond the segment's effective limit, or a segment that is not usable. The 20-bit limit counts bytes when the granularity bit is clear. When the bit is set, the limit counts 4 KB units and the low 12 bits are filled with ones. A descriptor whose present bit is clear raises a one-cycle not-present pulse and leaves the segment unusable. Accesses stall while a fetch is in flight.

Top module: `seg_xlate`

## Requirements
- R1: After reset, busy, seg_valid, mem_req, np_fault and acc_ack are all 0.
- R2: A selector load drives mem_req with mem_addr = table base + selector*8 until mem_rvalid. It then drives mem_req with that address + 4 until the second mem_rvalid. The address is held stable while mem_req waits.
- R3: The descriptor is decoded from the low word w0 and the high word w1. Fields: base = {w1[31:24], w1[7:0], w0[31:16]}; limit = {w1[19:16], w0[15:0]}; type = w1[11:8]; system/app flag = w1[12]; privilege = w1[14:13]; present = w1[15]; spare bit = w1[20]; default size = w1[22]; granularity = w1[23]. Privilege, type, system flag, default size and spare bit appear on the attribute outputs.
- R4: An accepted access returns lin_addr = segment base + offset, modulo 2^32.
- R5: With granularity 0, an access faults with code 2'b01 exactly when offset > limit; otherwise the code is 2'b00.
- R6: With granularity 1, the effective limit is (limit << 12) | 0xFFF, and offset > effective limit gives code 2'b01.
- R7: If the fetched descriptor's present bit is 0, np_fault pulses for one cycle and seg_valid stays 0. Any access to a segment with seg_valid = 0 returns code 2'b10. A present descriptor sets seg_valid when the fetch completes.
- R8: busy is high from the cycle after a load until the second read completes. An access request is accepted only while busy is low, and acc_ack follows one cycle after acceptance.
- R9: A selector load presented while busy is ignored; the fetch in flight and its result are unchanged.
- R10: A table-base write affects only loads accepted after the write; a load in the same cycle uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_we | input | 1 | Table base write strobe |
| tbase_wdata | input | 32 | New table base byte address |
| sel_load | input | 1 | Load selector strobe |
| sel_value | input | 16 | Selector to load |
| mem_req | output | 1 | Read request to table memory |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid for the pending request |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Descriptor fetch in flight |
| seg_valid | output | 1 | Hidden segment register holds a present descriptor |
| np_fault | output | 1 | One-cycle pulse: fetched descriptor not present |
| seg_dpl | output | 2 | Privilege level of loaded descriptor |
| seg_type | output | 4 | Type field of loaded descriptor |
| seg_sys | output | 1 | System/application flag |
| seg_db | output | 1 | Default size flag |
| seg_avl | output | 1 | Software-available bit |
| acc_req | input | 1 | Access request |
| acc_offset | input | 32 | Access offset |
| acc_ack | output | 1 | Access result valid |
| lin_addr | output | 32 | Linear address |
| acc_fault | output | 2 | 00 ok, 01 limit, 10 segment not usable |

## Verification
The bench builds the block with GRAN_SHIFT left at 12, the 4 KB unit. With that value, a granular descriptor whose limit is all ones reaches an effective limit of 0xFFFFFFFF. This lets the bench show base-plus-offset wraparound. Offsets at one below, at and one above each limit check both scaling modes. The table memory model answers with zero and with several wait states. This keeps requests pending, so stalled accesses and selector loads ignored mid-fetch occur. A second table base shows that the new base applies only to later loads.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int GRAN_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbase_we,
  input  logic [31:0] tbase_wdata,
  input  logic        sel_load,
  input  logic [15:0] sel_value,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        seg_valid,
  output logic        np_fault,
  output logic [1:0]  seg_dpl,
  output logic [3:0]  seg_type,
  output logic        seg_sys,
  output logic        seg_db,
  output logic        seg_avl,
  input  logic        acc_req,
  input  logic [31:0] acc_offset,
  output logic        acc_ack,
  output logic [31:0] lin_addr,
  output logic [1:0]  acc_fault
);

  localparam logic [31:0] GMASK = (32'd1 << GRAN_SHIFT) - 32'd1;
  localparam logic [1:0] F_OK = 2'b00, F_LIM = 2'b01, F_NP = 2'b10;

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_t;

  phase_t      phase;
  logic [31:0] tbase, fetch_addr, w_lo;
  logic [31:0] seg_base, seg_elim;

  logic [31:0] d_base, d_elim;
  logic [19:0] d_lim;
  logic        d_gran, d_present;

  assign d_base    = {mem_rdata[31:24], mem_rdata[7:0], w_lo[31:16]};
  assign d_lim     = {mem_rdata[19:16], w_lo[15:0]};
  assign d_gran    = mem_rdata[23];
  assign d_present = mem_rdata[15];
  assign d_elim    = d_gran ? (({12'd0, d_lim} << GRAN_SHIFT) | GMASK) : {12'd0, d_lim};

  assign mem_req  = (phase != PH_IDLE);
  assign busy     = mem_req;
  assign mem_addr = fetch_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      tbase      <= '0;
      fetch_addr <= '0;
      w_lo       <= '0;
      seg_base   <= '0;
      seg_elim   <= '0;
      seg_valid  <= 1'b0;
      np_fault   <= 1'b0;
      seg_dpl    <= '0;
      seg_type   <= '0;
      seg_sys    <= 1'b0;
      seg_db     <= 1'b0;
      seg_avl    <= 1'b0;
    end else begin
      np_fault <= 1'b0;
      if (tbase_we) tbase <= tbase_wdata;
      unique case (phase)
        PH_IDLE: if (sel_load) begin
          fetch_addr <= tbase + {13'd0, sel_value, 3'b000};
          seg_valid  <= 1'b0;
          phase      <= PH_LO;
        end
        PH_LO: if (mem_rvalid) begin
          w_lo       <= mem_rdata;
          fetch_addr <= fetch_addr + 32'd4;
          phase      <= PH_HI;
        end
        PH_HI: if (mem_rvalid) begin
          seg_base  <= d_base;
          seg_elim  <= d_elim;
          seg_type  <= mem_rdata[11:8];
          seg_sys   <= mem_rdata[12];
          seg_dpl   <= mem_rdata[14:13];
          seg_avl   <= mem_rdata[20];
          seg_db    <= mem_rdata[22];
          seg_valid <= d_present;
          np_fault  <= ~d_present;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_ack   <= 1'b0;
      lin_addr  <= '0;
      acc_fault <= F_OK;
    end else begin
      acc_ack <= acc_req & ~busy;
      if (acc_req && !busy) begin
        lin_addr  <= seg_base + acc_offset;
        acc_fault <= !seg_valid ? F_NP : (acc_offset > seg_elim ? F_LIM : F_OK);
      end
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  p_next_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && phase == PH_LO) |=> (mem_req && mem_addr == $past(mem_addr) + 32'd4));

  p_ack_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> ($past(acc_req) && !$past(busy)));

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !busy);

  p_np_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    np_fault |-> !seg_valid);

  p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> (acc_fault != 2'b11));

  p_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_load && !mem_rvalid) |=> $stable(mem_addr));

endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbase_we = 0, sel_load = 0, mem_rvalid = 0, acc_req = 0;
  logic [31:0] tbase_wdata = 0, mem_rdata = 0, acc_offset = 0;
  logic [15:0] sel_value = 0;
  logic mem_req, busy, seg_valid, np_fault, seg_sys, seg_db, seg_avl, acc_ack;
  logic [31:0] mem_addr, lin_addr;
  logic [1:0] seg_dpl, acc_fault;
  logic [3:0] seg_type;

  seg_xlate dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, lat_sel = 0, wcnt = 0;
  logic [31:0] mem [0:255];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return (a[31:10] == 0) ? mem[a[9:2]] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] base, input logic [19:0] lim,
                          input bit g, input bit p, input logic [1:0] dpl, input logic [3:0] typ,
                          input bit s, input bit db, input bit avl);
    mem[a[9:2]]     = {base[15:0], lim[15:0]};
    mem[a[9:2] + 1] = {base[31:24], g, db, 1'b0, avl, lim[19:16], p, dpl, s, typ, base[23:16]};
  endtask

  // memory responder: answers after lat_sel wait cycles
  always @(posedge clk) begin
    #2;
    if (mem_req && wcnt == 0) begin
      mem_rvalid = 1'b1;
      mem_rdata  = rd(mem_addr);
      wcnt       = lat_sel;
    end else begin
      mem_rvalid = 1'b0;
      if (mem_req) wcnt = wcnt - 1;
    end
  end

  // behavioural reference model
  int          m_phase = 0;
  logic [31:0] m_tb = 0, m_fa = 0, m_base = 0, m_elim = 0, e_lin = 0;
  bit          e_valid = 0, e_np = 0, e_ack = 0;
  logic [1:0]  e_fault = 0, e_dpl = 0;
  logic [3:0]  e_type = 0;
  bit          e_sys = 0, e_db = 0, e_avl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_tb = 0; m_fa = 0; m_base = 0; m_elim = 0;
      e_valid = 0; e_np = 0; e_ack = 0; e_lin = 0; e_fault = 0;
    end else begin
      logic [31:0] w0, w1;
      longint unsigned lim;
      e_np  = 0;
      e_ack = acc_req && (m_phase == 0);
      if (e_ack) begin
        e_lin   = m_base + acc_offset;
        e_fault = !e_valid ? 2'b10 : ((acc_offset > m_elim) ? 2'b01 : 2'b00);
      end
      if (m_phase == 0) begin
        if (sel_load) begin
          m_fa = m_tb + 32'(sel_value) * 8;
          e_valid = 0;
          m_phase = 1;
        end
      end else if (mem_rvalid) begin
        if (m_phase == 1) m_phase = 2;
        else begin
          w0 = rd(m_fa); w1 = rd(m_fa + 4);
          m_base = {w1[31:24], w1[7:0], w0[31:16]};
          lim    = {w1[19:16], w0[15:0]};
          m_elim = w1[23] ? 32'(lim * 4096 + 4095) : 32'(lim);
          e_type = w1[11:8]; e_sys = w1[12]; e_dpl = w1[14:13];
          e_avl = w1[20]; e_db = w1[22];
          e_valid = w1[15]; e_np = !w1[15];
          m_phase = 0;
        end
      end
      if (tbase_we) m_tb = tbase_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy && !seg_valid && !mem_req && !np_fault && !acc_ack, "R1",
          {27'd0, busy, seg_valid, mem_req, np_fault, acc_ack}, 32'd0);
    end else begin
      chk(busy == (m_phase != 0), "R8 busy", 32'(busy), 32'(m_phase != 0));
      chk(mem_req == (m_phase != 0), "R2 req", 32'(mem_req), 32'(m_phase != 0));
      if (m_phase != 0)
        chk(mem_addr == (m_phase == 1 ? m_fa : m_fa + 4), "R2 addr", mem_addr, m_phase == 1 ? m_fa : m_fa + 4);
      chk(seg_valid == e_valid, "R7 valid", 32'(seg_valid), 32'(e_valid));
      chk(np_fault == e_np, "R7 np", 32'(np_fault), 32'(e_np));
      chk(acc_ack == e_ack, "R8 ack", 32'(acc_ack), 32'(e_ack));
      if (e_ack) begin
        chk(lin_addr == e_lin, "R4 lin", lin_addr, e_lin);
        chk(acc_fault == e_fault, "R5 R6 fault", 32'(acc_fault), 32'(e_fault));
      end
      if (e_valid)
        chk({seg_dpl, seg_type, seg_sys, seg_db, seg_avl} == {e_dpl, e_type, e_sys, e_db, e_avl}, "R3 attr",
            32'({seg_dpl, seg_type, seg_sys, seg_db, seg_avl}), 32'({e_dpl, e_type, e_sys, e_db, e_avl}));
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic load(input logic [15:0] s);
    @(posedge clk); #2 sel_load = 1; sel_value = s;
    @(posedge clk); #2 sel_load = 0;
    wait_idle();
  endtask

  task automatic access(input logic [31:0] off, input logic [31:0] exp_lin, input logic [1:0] exp_f, input string req);
    @(posedge clk); #2 acc_req = 1; acc_offset = off;
    @(posedge clk); #2 acc_req = 0;
    @(negedge clk);
    chk(acc_ack && lin_addr == exp_lin, req, lin_addr, exp_lin);
    chk(acc_fault == exp_f, req, 32'(acc_fault), 32'(exp_f));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    put_desc(32'h40, 32'h1000_0000, 20'h00FFF, 0, 1, 2'd3, 4'h2, 1, 1, 0);
    put_desc(32'h48, 32'h0020_0000, 20'h00003, 1, 1, 2'd1, 4'hA, 0, 0, 1);
    put_desc(32'h50, 32'h3000_0000, 20'h00100, 0, 0, 2'd0, 4'h2, 1, 0, 0);
    put_desc(32'h58, 32'hFFFF_F000, 20'hFFFFF, 1, 1, 2'd2, 4'h3, 1, 1, 1);
    put_desc(32'h200, 32'h5555_0000, 20'h00010, 0, 1, 2'd0, 4'h6, 1, 0, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2 tbase_we = 1; tbase_wdata = 32'h40;
    @(posedge clk); #2 tbase_we = 0;
    // R7: access before any load sees an unusable segment
    access(32'h0, 32'h0, 2'b10, "R7 pre-load");
    // R9, R8: load sel 0 with wait states, stall an access and try a second load mid-fetch
    lat_sel = 2;
    @(posedge clk); #2 sel_load = 1; sel_value = 16'd0;
    @(posedge clk); #2 sel_load = 0; acc_req = 1; acc_offset = 32'h10;
    @(posedge clk); #2 sel_load = 1; sel_value = 16'd1;
    @(posedge clk); #2 sel_load = 0;
    wait_idle();
    @(posedge clk); #2 acc_req = 0;
    wait_idle();
    lat_sel = 0;
    access(32'h10, 32'h1000_0010, 2'b00, "R9 sel0 kept");
    access(32'h0FFF, 32'h1000_0FFF, 2'b00, "R5 at limit");
    access(32'h1000, 32'h1000_1000, 2'b01, "R5 above limit");
    chk(seg_dpl == 2'd3 && seg_type == 4'h2 && seg_sys && seg_db && !seg_avl, "R3 sel0 attr",
        32'({seg_dpl, seg_type, seg_sys, seg_db, seg_avl}), 32'({2'd3, 4'h2, 3'b110}));
    load(16'd1);
    access(32'h3FFF, 32'h0020_3FFF, 2'b00, "R6 at limit");
    access(32'h4000, 32'h0020_4000, 2'b01, "R6 above limit");
    load(16'd2);
    chk(!seg_valid, "R7 not present", 32'(seg_valid), 32'd0);
    access(32'h0, 32'h3000_0000, 2'b10, "R7 access np");
    lat_sel = 1;
    load(16'd3);
    access(32'h2000, 32'h0000_1000, 2'b00, "R4 wrap");
    access(32'hFFFF_FFFF, 32'hFFFF_EFFF, 2'b00, "R6 max limit");
    // R10: base write in the same cycle as a load uses the old base
    lat_sel = 0;
    @(posedge clk); #2 sel_load = 1; sel_value = 16'd0; tbase_we = 1; tbase_wdata = 32'h200;
    @(posedge clk); #2 sel_load = 0; tbase_we = 0;
    wait_idle();
    access(32'h4, 32'h1000_0004, 2'b00, "R10 old base");
    load(16'd0);
    access(32'h4, 32'h5555_0004, 2'b00, "R10 new base");
    access(32'h11, 32'h5555_0011, 2'b01, "R5 new table limit");
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule